// File: doc/BRIEF.md
# Erase-Block Write-Protect Lock Manager

This block holds a protection record for every erase block of a flash array. Each record is in one of three states: open for writes, locked, or sealed. A sealed record is locked until the next cold reset. Two range registers name a first and a last block. Four commands walk the table, one block per clock: lock a range, unlock a range, unlock the whole array, and seal a range. While a walk runs, the block raises a busy flag and ignores new commands and range writes. It raises an interrupt flag when the walk ends.

The state most recently written into the table is mirrored in a 16-bit status word. A walk that runs past the last block sets an error flag. A combinational lookup port returns the state of any block. The erase and program gating logic uses this port to decide whether an operation may proceed.

Top module: `wp_lock_mgr`

## Requirements
- R1: Block states are one-hot 3-bit codes: sealed = 3'b001, locked = 3'b010, open = 3'b100. `q_state` returns the code of block `q_blk` in the same cycle.
- R2: After a cold reset every block reads locked. `wp_status` is 0x0002. `busy`, `irq` and `cmd_err` are 0, and both range registers are 0.
- R3: A write to the first-block register stores `reg_wdata & (NUM_BLOCKS-1)` into both range registers. A write to the last-block register updates only that register, and it wins over the copy if both writes come in the same cycle. Range writes are ignored while `busy` is high.
- R4: Range unlock (opcode 0x23) and range lock (opcode 0x2A) visit the blocks from first to last inclusive, one per clock. `busy` stays high for one cycle per visited block.
- R5: In range lock or range unlock, reaching a sealed block ends the walk in that cycle. That block and every later block keep their state.
- R6: Unlock-all (opcode 0x27) ignores the range registers and visits blocks 0 to NUM_BLOCKS-1. It stops at the first sealed block.
- R7: Range seal (opcode 0x2C) leaves open blocks unchanged and sets every other visited block to sealed.
- R8: If the walk index reaches NUM_BLOCKS (first block above last block), `cmd_err` is set, the walk ends, and only the blocks from first to NUM_BLOCKS-1 were visited.
- R9: Every table write also loads the new 3-bit code into the low bits of `wp_status`. The upper bits of `wp_status` are zero.
- R10: `irq` is set in the cycle any of the four commands ends. `irq_clr` clears `irq` and `cmd_err`, but a walk that ends in the same cycle wins over the clear.
- R11: While `busy` is high, a command is ignored. A command with any other opcode is always ignored and does not raise `busy`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low cold reset |
| start_we | input | 1 | Write strobe for the first-block register |
| end_we | input | 1 | Write strobe for the last-block register |
| reg_wdata | input | 16 | Data for the range register writes |
| cmd_we | input | 1 | Command strobe |
| cmd_op | input | 8 | Command opcode |
| irq_clr | input | 1 | Clears the interrupt and error flags |
| q_blk | input | log2(NUM_BLOCKS) | Block index for the lookup port |
| q_state | output | 3 | State code of block `q_blk` |
| start_blk | output | 16 | First-block register |
| end_blk | output | 16 | Last-block register |
| busy | output | 1 | A walk is in progress |
| irq | output | 1 | Command-complete flag |
| cmd_err | output | 1 | The walk ran past the last block |
| wp_status | output | 16 | Last state code written into the table |

## Verification
Timing after each stimulus:
- A range write is visible on the range outputs one cycle after its strobe.
- An accepted command raises `busy` after the next edge.
- The block visited in a given busy cycle shows its new code on `q_state`, and in `wp_status`, after that cycle's edge.
- `irq`, `cmd_err` and the fall of `busy` all appear after the edge that handles the last visited block.

The bench keeps a behavioural reference model that is updated at each rising edge from the inputs that were stable across that edge. It compares every output to the model 2 ns after the edge, so each result is checked in the exact cycle it is due. The lookup index steps through every block in turn, so the whole table is checked once every NUM_BLOCKS cycles.

// File: rtl/wp_lock_mgr.sv
module wp_lock_mgr #(
  parameter int NUM_BLOCKS = 64,
  parameter int REG_W      = 16
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          start_we,
  input  logic                          end_we,
  input  logic [REG_W-1:0]              reg_wdata,
  input  logic                          cmd_we,
  input  logic [7:0]                    cmd_op,
  input  logic                          irq_clr,
  input  logic [$clog2(NUM_BLOCKS)-1:0] q_blk,
  output logic [2:0]                    q_state,
  output logic [REG_W-1:0]              start_blk,
  output logic [REG_W-1:0]              end_blk,
  output logic                          busy,
  output logic                          irq,
  output logic                          cmd_err,
  output logic [REG_W-1:0]              wp_status
);
  localparam int IW = $clog2(NUM_BLOCKS);
  localparam int CW = IW + 1;
  localparam logic [CW-1:0]    LIMIT = CW'(NUM_BLOCKS);
  localparam logic [CW-1:0]    LAST  = CW'(NUM_BLOCKS - 1);
  localparam logic [REG_W-1:0] MASK  = REG_W'(NUM_BLOCKS - 1);

  localparam logic [2:0] ST_SEAL = 3'b001;
  localparam logic [2:0] ST_LOCK = 3'b010;
  localparam logic [2:0] ST_OPEN = 3'b100;

  localparam logic [7:0] OP_UNLOCK     = 8'h23;
  localparam logic [7:0] OP_UNLOCK_ALL = 8'h27;
  localparam logic [7:0] OP_LOCK       = 8'h2A;
  localparam logic [7:0] OP_SEAL       = 8'h2C;

  localparam logic [1:0] K_OPEN = 2'd0;
  localparam logic [1:0] K_LOCK = 2'd1;
  localparam logic [1:0] K_SEAL = 2'd2;

  logic [2:0]       tbl [NUM_BLOCKS];
  logic [REG_W-1:0] first_q, last_q;
  logic [CW-1:0]    walk, stop_at;
  logic [1:0]       kind;
  logic             busy_q, irq_q, err_q;
  logic [2:0]       stat_q;

  wire is_unlock_all = (cmd_op == OP_UNLOCK_ALL);
  wire known  = (cmd_op == OP_UNLOCK) || is_unlock_all ||
                (cmd_op == OP_LOCK)   || (cmd_op == OP_SEAL);
  wire launch = cmd_we && !busy_q && known;

  wire [1:0] new_kind = (cmd_op == OP_LOCK) ? K_LOCK :
                        (cmd_op == OP_SEAL) ? K_SEAL : K_OPEN;

  wire       oob     = walk >= LIMIT;
  wire [2:0] cur     = tbl[walk[IW-1:0]];
  wire [2:0] fill    = (kind == K_OPEN) ? ST_OPEN :
                       (kind == K_LOCK) ? ST_LOCK : ST_SEAL;
  wire       blocked = (kind != K_SEAL) && (cur == ST_SEAL);
  wire       skip    = (kind == K_SEAL) && (cur == ST_OPEN);
  wire       do_wr   = busy_q && !oob && !blocked && !skip;
  wire       finish  = busy_q && (oob || blocked || (walk == stop_at));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      first_q <= '0;
      last_q  <= '0;
    end else if (!busy_q) begin
      if (start_we) first_q <= reg_wdata & MASK;
      if (end_we || start_we) last_q <= reg_wdata & MASK;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      walk    <= '0;
      stop_at <= '0;
      kind    <= K_OPEN;
      irq_q   <= 1'b0;
      err_q   <= 1'b0;
      stat_q  <= ST_LOCK;
    end else begin
      if (launch) begin
        busy_q  <= 1'b1;
        kind    <= new_kind;
        walk    <= is_unlock_all ? '0   : CW'(first_q[IW-1:0]);
        stop_at <= is_unlock_all ? LAST : CW'(last_q[IW-1:0]);
      end else if (finish) begin
        busy_q <= 1'b0;
      end else if (busy_q) begin
        walk <= walk + 1'b1;
      end
      if (do_wr) stat_q <= fill;
      irq_q <= finish ? 1'b1 : (irq_clr ? 1'b0 : irq_q);
      err_q <= (finish && oob) ? 1'b1 : (irq_clr ? 1'b0 : err_q);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_BLOCKS; i++) tbl[i] <= ST_LOCK;
    end else if (do_wr) begin
      tbl[walk[IW-1:0]] <= fill;
    end
  end

  assign q_state   = tbl[q_blk];
  assign start_blk = first_q;
  assign end_blk   = last_q;
  assign busy      = busy_q;
  assign irq       = irq_q;
  assign cmd_err   = err_q;
  assign wp_status = {{(REG_W-3){1'b0}}, stat_q};
endmodule

// File: rtl/wp_lock_mgr_chk.sv
module wp_lock_mgr_chk #(
  parameter int REG_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_we,
  input logic             end_we,
  input logic             busy,
  input logic             irq,
  input logic             cmd_err,
  input logic [2:0]       q_state,
  input logic [REG_W-1:0] start_blk,
  input logic [REG_W-1:0] end_blk,
  input logic [REG_W-1:0] wp_status
);
  a_r1_state_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(q_state) == 1);

  a_r9_status_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(wp_status) == 1);

  a_r3_end_copies_start: assert property (@(posedge clk) disable iff (!rst_n)
    (start_we && !end_we && !busy) |=> (end_blk == start_blk));

  a_r3_frozen_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(start_blk) && $stable(end_blk)));

  a_r8_err_ends_walk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmd_err) |-> $fell(busy));

  a_r10_irq_at_finish: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> irq);
endmodule

bind wp_lock_mgr wp_lock_mgr_chk #(.REG_W(REG_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start_we(start_we), .end_we(end_we),
  .busy(busy), .irq(irq), .cmd_err(cmd_err), .q_state(q_state),
  .start_blk(start_blk), .end_blk(end_blk), .wp_status(wp_status)
);

// File: tb/wp_lock_mgr_test.sv
module wp_lock_mgr_test;
  localparam int N = 16;

  logic clk = 0;
  always #4 clk = ~clk;

  logic        rst_n = 0, start_we = 0, end_we = 0, cmd_we = 0, irq_clr = 0;
  logic [15:0] reg_wdata = 0;
  logic [7:0]  cmd_op = 0;
  logic [3:0]  q_blk = 0;
  wire  [2:0]  q_state;
  wire  [15:0] start_blk, end_blk, wp_status;
  wire         busy, irq, cmd_err;

  wp_lock_mgr #(.NUM_BLOCKS(N), .REG_W(16)) uut (
    .clk(clk), .rst_n(rst_n), .start_we(start_we), .end_we(end_we),
    .reg_wdata(reg_wdata), .cmd_we(cmd_we), .cmd_op(cmd_op), .irq_clr(irq_clr),
    .q_blk(q_blk), .q_state(q_state), .start_blk(start_blk), .end_blk(end_blk),
    .busy(busy), .irq(irq), .cmd_err(cmd_err), .wp_status(wp_status)
  );

  int    n_cmp = 0, n_bad = 0;
  string tag = "R2";
  bit    done = 0;

  // reference model: codes 1 sealed, 2 locked, 4 open; kinds 0 open, 1 lock, 2 seal
  int m_tbl[N];
  int m_start, m_end, m_busy, m_irq, m_err, m_status, m_pos, m_last, m_kind;

  task automatic m_reset();
    foreach (m_tbl[i]) m_tbl[i] = 2;
    m_start = 0; m_end = 0; m_busy = 0; m_irq = 0; m_err = 0;
    m_status = 2; m_pos = 0; m_last = 0; m_kind = 0;
  endtask

  initial m_reset();

  always @(posedge clk) begin
    if (!rst_n) m_reset();
    else begin
      int was_busy;
      was_busy = m_busy;
      if (irq_clr) begin m_irq = 0; m_err = 0; end
      if (m_busy) begin
        if (m_pos >= N) begin
          m_err = 1; m_irq = 1; m_busy = 0;
        end else begin
          int s, halt, want;
          s = m_tbl[m_pos];
          halt = 0;
          want = (m_kind == 0) ? 4 : (m_kind == 1) ? 2 : 1;
          if (m_kind == 2) begin
            if (s != 4) begin m_tbl[m_pos] = 1; m_status = 1; end
          end else if (s == 1) halt = 1;
          else begin m_tbl[m_pos] = want; m_status = want; end
          if (halt || m_pos == m_last) begin m_busy = 0; m_irq = 1; end
          else m_pos++;
        end
      end
      if (!was_busy) begin
        if (start_we) begin m_start = reg_wdata % N; m_end = reg_wdata % N; end
        if (end_we) m_end = reg_wdata % N;
        if (cmd_we && (cmd_op == 8'h23 || cmd_op == 8'h27 ||
                       cmd_op == 8'h2A || cmd_op == 8'h2C)) begin
          m_busy = 1;
          m_kind = (cmd_op == 8'h2A) ? 1 : (cmd_op == 8'h2C) ? 2 : 0;
          m_pos  = (cmd_op == 8'h27) ? 0 : m_start;
          m_last = (cmd_op == 8'h27) ? N - 1 : m_end;
        end
      end
    end
  end

  task automatic chk(string what, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    #2;
    if (!done) begin
      chk("busy", busy, m_busy);
      chk("irq", irq, m_irq);
      chk("cmd_err", cmd_err, m_err);
      chk("wp_status", wp_status, m_status);
      chk("start_blk", start_blk, m_start);
      chk("end_blk", end_blk, m_end);
      chk($sformatf("q_state[%0d]", q_blk), q_state, m_tbl[q_blk]);
      q_blk = q_blk + 1'b1;
    end
  end

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  task automatic wr_start(input int v);
    @(negedge clk); start_we = 1; reg_wdata = 16'(v);
    @(negedge clk); start_we = 0;
  endtask

  task automatic wr_end(input int v);
    @(negedge clk); end_we = 1; reg_wdata = 16'(v);
    @(negedge clk); end_we = 0;
  endtask

  task automatic clr();
    @(negedge clk); irq_clr = 1;
    @(negedge clk); irq_clr = 0;
  endtask

  task automatic run(input logic [7:0] op);
    @(negedge clk); cmd_we = 1; cmd_op = op;
    @(negedge clk); cmd_we = 0;
    while (busy) @(negedge clk);
    repeat (N + 1) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    tag = "R2";
    repeat (N + 2) @(negedge clk);

    tag = "R3";
    wr_start(16'h0013);
    wr_end(7);
    wr_start(5);
    @(negedge clk); start_we = 1; end_we = 1; reg_wdata = 16'd9;
    @(negedge clk); start_we = 0; end_we = 0;

    tag = "R4 R1 R9";
    wr_start(2); wr_end(6); run(8'h23); clr();
    wr_start(4); wr_end(5); run(8'h2A); clr();

    tag = "R6";
    run(8'h27); clr();
    wr_start(0); wr_end(15); run(8'h2A); clr();

    tag = "R7";
    wr_start(2); wr_end(3); run(8'h23);
    wr_start(6); run(8'h23);
    wr_start(0); wr_end(7); run(8'h2C); clr();

    tag = "R5";
    wr_start(6); wr_end(10); run(8'h2A); clr();
    wr_start(3); wr_end(9); run(8'h23); clr();
    tag = "R6 R5";
    run(8'h27); clr();

    tag = "R8 R10";
    wr_start(12); wr_end(3); run(8'h2A); clr();

    tag = "R11";
    run(8'h55);
    wr_start(8); wr_end(15);
    @(negedge clk); cmd_we = 1; cmd_op = 8'h2C;
    @(negedge clk); cmd_op = 8'h27; start_we = 1; reg_wdata = 16'd1;
    @(negedge clk); cmd_we = 0; start_we = 0; end_we = 1; reg_wdata = 16'd2;
    @(negedge clk); end_we = 0;
    while (busy) @(negedge clk);
    repeat (N + 1) @(negedge clk);

    tag = "R2";
    rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    repeat (N + 2) @(negedge clk);

    done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
      $finish;
    end
  end
endmodule